// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block sits between the interrupt request line of the I/O devices and the next-address logic of a simple single-cycle processor. It samples the level-sensitive request on every rising clock edge. If interrupts are currently enabled, it accepts the request. Acceptance does three things in the same step:

- It raises an acknowledge pulse so the device can withdraw its request.
- It raises a divert select that tells the next-address multiplexer to fetch from a fixed service-routine address.
- It disables further interrupts.

It also records the next sequential program counter as the return address, so software can save it before it enables interrupts again.

Software controls the enable state with two inputs. One clears the mask and the other sets it. An acceptance always leaves interrupts disabled, even if the clear input was active in the same cycle. A request that arrives while interrupts are disabled is not consumed. It stays on the line and is accepted on the first edge after software enables interrupts again.

Top module: `irq_accept`

## Requirements
- R1: While reset is low and on the first cycle after it, `irq_masked` is 1, `irq_ack` and `irq_divert` are 0, and `ret_pc` is 0.
- R2: A request sampled at an edge where `irq_masked` is 1 produces no acknowledge and no divert in the following cycle.
- R3: A request sampled high at an edge where `irq_masked` is 0 makes `irq_ack` and `irq_divert` both 1 for exactly the one following cycle.
- R4: `handler_pc` always equals the parameter `HANDLER_PC` (default 0x00000180).
- R5: On acceptance, `ret_pc` takes the value `pc_seq` had at the accepting edge. Without an acceptance, `ret_pc` keeps its value.
- R6: An acceptance sets `irq_masked` to 1. A request held high afterwards gives no second acknowledge until interrupts are enabled again.
- R7: With no acceptance, `mask_set`=1 sets `irq_masked` to 1, `mask_clr`=1 alone clears it to 0, and when both are 1 the set wins.
- R8: If an acceptance and `mask_clr` fall on the same edge, `irq_masked` is 1 afterwards.
- R9: A request left pending while masked is accepted at the first edge at which `irq_masked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level-sensitive interrupt request from the devices |
| mask_clr | input | 1 | Enable interrupts (clear the mask) |
| mask_set | input | 1 | Disable interrupts (set the mask) |
| pc_seq | input | AW | Address of the next sequential instruction |
| irq_ack | output | 1 | One-cycle acknowledge to the device |
| irq_divert | output | 1 | Selects the handler address in the next-address multiplexer |
| irq_masked | output | 1 | Current mask state (1 = interrupts disabled) |
| handler_pc | output | AW | Fixed service-routine address |
| ret_pc | output | AW | Return address captured at acceptance |

## Verification
The assertions take for granted that `irq_req`, `mask_clr` and `mask_set` are synchronous to `clk` and stable around the rising edge. They assume no value on these inputs is illegal, including both mask controls being active at once. The stimulus changes inputs only on the falling edge. It walks every combination of request and the two mask controls from both mask states. It then drives a long pseudo-random stream in which the set control is rarer than the clear control, so acceptances, held requests and same-edge conflicts all occur often.

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int AW = 32,
  parameter logic [AW-1:0] HANDLER_PC = AW'(32'h0000_0180)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          mask_clr,
  input  logic          mask_set,
  input  logic [AW-1:0] pc_seq,
  output logic          irq_ack,
  output logic          irq_divert,
  output logic          irq_masked,
  output logic [AW-1:0] handler_pc,
  output logic [AW-1:0] ret_pc
);

  logic          masked_q;
  logic          taken_q;
  logic [AW-1:0] ret_q;
  logic          take;

  assign take = irq_req && !masked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masked_q <= 1'b1;
      taken_q  <= 1'b0;
      ret_q    <= '0;
    end else begin
      taken_q <= take;
      if (take)
        ret_q <= pc_seq;
      if (take || mask_set)
        masked_q <= 1'b1;
      else if (mask_clr)
        masked_q <= 1'b0;
    end
  end

  assign irq_ack    = taken_q;
  assign irq_divert = taken_q;
  assign irq_masked = masked_q;
  assign handler_pc = HANDLER_PC;
  assign ret_pc     = ret_q;

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_masked_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked |=> !irq_ack);

  p_take_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> irq_masked);

  p_ret_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ret_pc == $past(pc_seq));

  p_ret_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |-> $stable(ret_pc));

  p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr && !mask_set && !irq_req) |=> !irq_masked);

  p_take_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_masked) |=> (irq_masked && irq_ack));

endmodule

// File: tb/irq_accept_tb_top.sv
module irq_accept_tb_top;
  localparam int AW = 32;
  localparam logic [AW-1:0] HP = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_req, mask_clr, mask_set;
  logic [AW-1:0] pc_seq;
  logic irq_ack, irq_divert, irq_masked;
  logic [AW-1:0] handler_pc, ret_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic m_mask, m_ack;
  logic [AW-1:0] m_ret;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  irq_accept #(.AW(AW), .HANDLER_PC(HP)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_clr(mask_clr),
    .mask_set(mask_set), .pc_seq(pc_seq), .irq_ack(irq_ack),
    .irq_divert(irq_divert), .irq_masked(irq_masked),
    .handler_pc(handler_pc), .ret_pc(ret_pc));

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "ack", AW'(irq_ack), AW'(m_ack));
    chk(tag, "divert", AW'(irq_divert), AW'(m_ack));
    chk(tag, "mask", AW'(irq_masked), AW'(m_mask));
    chk(tag, "ret", ret_pc, m_ret);
    chk("R4", "handler", handler_pc, HP);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic rq, input logic clr, input logic st, input logic [AW-1:0] pc);
    logic tk;
    irq_req = rq; mask_clr = clr; mask_set = st; pc_seq = pc;
    tk = rq && !m_mask;
    m_ack = tk;
    if (tk) m_ret = pc;
    if (tk || st) m_mask = 1'b1;
    else if (clr) m_mask = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_req = 1'b1; mask_clr = 1'b1; mask_set = 1'b0; pc_seq = '1;
    m_mask = 1'b1; m_ack = 1'b0; m_ret = '0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    irq_req = 1'b0; mask_clr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2, R3, R7: every input combination from both mask states
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 8; v++) begin
        step(1'b0, s == 0, s == 1, 32'h0);
        chk_all("R7");
        step(v[0], v[1], v[2], 32'h1000 + 32'(v));
        chk_all(s == 1 ? "R2" : "R3");
        step(1'b0, 1'b0, 1'b0, 32'h0);
        chk_all("R3");
      end
    end

    // R6: request held high after acceptance, no second acknowledge
    step(1'b0, 1'b1, 1'b0, 32'h0);
    step(1'b1, 1'b0, 1'b0, 32'h2000);
    chk_all("R6");
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, 1'b0, 32'h2100 + 32'(i));
      chk_all("R6");
    end

    // R9: pending request accepted right after re-enable
    step(1'b1, 1'b1, 1'b0, 32'h3000);
    chk_all("R9");
    step(1'b1, 1'b0, 1'b0, 32'h3004);
    chk_all("R9");

    // R8: acceptance and enable on the same edge
    step(1'b1, 1'b0, 1'b0, 32'h4000);
    chk_all("R8");
    step(1'b0, 1'b1, 1'b0, 32'h0);
    chk_all("R7");
    step(1'b1, 1'b1, 1'b0, 32'h4444);
    chk_all("R8");

    // R5: ret_pc holds across many cycles without acceptance
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b0, 32'hDEAD_0000 + 32'(i));
      chk_all("R5");
    end

    // Pseudo-random stream
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] | lfsr[2], lfsr[3] & lfsr[4] & lfsr[5], {lfsr, ~lfsr});
      chk_all("R5");
    end

    finish_run();
  end
endmodule